// File: doc/BRIEF.md
# Pipeline RAW Hazard and Forwarding Control

This unit sits beside the decode stage of an in-order five-stage integer pipeline and resolves read-after-write dependences. Each cycle it compares the two source register numbers of the decoding instruction with the destination numbers held in the EX, MEM and WB pipeline registers. From that comparison it produces one bypass mux select per operand, a stall that freezes fetch and decode, and a bubble that turns the instruction entering EX into a no-op.

A load in EX whose result is needed by the decoding instruction cannot be bypassed in time, so the unit stalls for one cycle and inserts a bubble. There is one exception. When the consumer is a store that needs the loaded value only as its store data, the unit does not stall. It records the case and, two cycles later, when the store is in MEM and the load in WB, raises a select that routes the loaded value into the store data. Register file, ALU and memories live outside the unit.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Register 0 never matches any stage: an operand whose source is 0 always selects 00, and a destination of 0 never causes a stall.
- R2: A stage whose write enable is low never causes a forward, a stall or a store-data bypass, whatever its destination number and load flag.
- R3: Each operand select uses the code 00 register file, 01 EX result, 10 MEM result, 11 WB result. When several stages match, EX wins over MEM and MEM wins over WB.
- R4: When EX holds a writing load whose nonzero destination equals the decode rs, or equals the decode rt while the decode instruction is not a store, stall_o and bubble_o are both high in that same cycle. In every other cycle both are low.
- R5: When the decode instruction is a store, EX holds a writing load whose nonzero destination equals rt and differs from rs, there is no stall. In that case the rt select ignores EX and takes the nearest of MEM, WB or the register file.
- R6: st_fwd_mem_o is high in exactly the cycle two clock edges after an R5 cycle, and low otherwise.
- R7: While rst_ni is low, st_fwd_mem_o is low and any pending store-data bypass is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| id_rs_i | input | REG_W | First source register of the decode instruction |
| id_rt_i | input | REG_W | Second source register (store data for stores) |
| id_store_i | input | 1 | Decode instruction is a store |
| ex_rd_i | input | REG_W | Destination register in EX |
| ex_we_i | input | 1 | EX instruction writes a register |
| ex_load_i | input | 1 | EX instruction is a load |
| mem_rd_i | input | REG_W | Destination register in MEM |
| mem_we_i | input | 1 | MEM instruction writes a register |
| wb_rd_i | input | REG_W | Destination register in WB |
| wb_we_i | input | 1 | WB instruction writes a register |
| fwd_a_o | output | 2 | Bypass select for rs |
| fwd_b_o | output | 2 | Bypass select for rt |
| stall_o | output | 1 | Hold fetch and decode |
| bubble_o | output | 1 | Replace the EX-bound instruction with a no-op |
| st_fwd_mem_o | output | 1 | Route the WB load value into the MEM store data |

## Verification
The bench sets up matches in all three stages at once to expose a wrong priority order, which would show up as a MEM or WB select where EX was expected. It also presents matches on register 0 and matches from stages whose write enable is low; a design that ignores either would forward from or stall on a non-writer. A store whose data depends on a load must pass without a stall and raise the memory-stage bypass exactly two cycles later, and a flag that is late, early or missing fails the check. A store whose address depends on the load must still stall, and a store depending on a non-load must forward from EX.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_EX  = 2'b01,
    SRC_MEM = 2'b10,
    SRC_WB  = 2'b11
  } byp_sel_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic             skip_ex_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_we_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output byp_sel_e         sel_o
);
  logic src_nz, hit_ex, hit_mem, hit_wb;

  assign src_nz  = |src_i;
  assign hit_ex  = src_nz && ex_we_i  && (ex_rd_i  == src_i) && !skip_ex_i;
  assign hit_mem = src_nz && mem_we_i && (mem_rd_i == src_i);
  assign hit_wb  = src_nz && wb_we_i  && (wb_rd_i  == src_i);

  always_comb begin
    if (hit_ex)       sel_o = SRC_EX;
    else if (hit_mem) sel_o = SRC_MEM;
    else if (hit_wb)  sel_o = SRC_WB;
    else              sel_o = SRC_RF;
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic             id_store_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_we_i,
  input  logic             ex_load_i,
  output logic             stall_o,
  output logic             st_case_o
);
  logic ld_live, rs_dep, rt_dep;

  assign ld_live = ex_load_i && ex_we_i && (|ex_rd_i);
  assign rs_dep  = ld_live && (id_rs_i == ex_rd_i);
  assign rt_dep  = ld_live && (id_rt_i == ex_rd_i);

  // store data can be patched in MEM; an address dependence cannot
  assign st_case_o = rt_dep && id_store_i && !rs_dep;
  assign stall_o   = rs_dep || (rt_dep && !id_store_i);
endmodule

// File: rtl/store_byp_track.sv
module store_byp_track #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic st_case_i,
  input  logic stall_i,
  output logic st_fwd_o
);
  logic [DEPTH-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= {pend_q[DEPTH-2:0], st_case_i && !stall_i};
  end

  assign st_fwd_o = pend_q[DEPTH-1];
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic             id_store_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_we_i,
  input  logic             ex_load_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o,
  output logic             stall_o,
  output logic             bubble_o,
  output logic             st_fwd_mem_o
);
  localparam int NOPS      = 2;
  localparam int ST_LATENCY = 2;  // decode -> EX -> MEM

  logic             stall, st_case;
  logic [REG_W-1:0] src   [NOPS];
  logic             skip  [NOPS];
  byp_sel_e         sel   [NOPS];

  assign src[0]  = id_rs_i;
  assign src[1]  = id_rt_i;
  assign skip[0] = 1'b0;
  assign skip[1] = st_case;

  load_use_detect #(.REG_W(REG_W)) i_detect (
    .id_rs_i    (id_rs_i),
    .id_rt_i    (id_rt_i),
    .id_store_i (id_store_i),
    .ex_rd_i    (ex_rd_i),
    .ex_we_i    (ex_we_i),
    .ex_load_i  (ex_load_i),
    .stall_o    (stall),
    .st_case_o  (st_case)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    fwd_select #(.REG_W(REG_W)) i_sel (
      .src_i     (src[g]),
      .skip_ex_i (skip[g]),
      .ex_rd_i   (ex_rd_i),
      .ex_we_i   (ex_we_i),
      .mem_rd_i  (mem_rd_i),
      .mem_we_i  (mem_we_i),
      .wb_rd_i   (wb_rd_i),
      .wb_we_i   (wb_we_i),
      .sel_o     (sel[g])
    );
  end

  store_byp_track #(.DEPTH(ST_LATENCY)) i_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .st_case_i (st_case),
    .stall_i   (stall),
    .st_fwd_o  (st_fwd_mem_o)
  );

  assign fwd_a_o  = sel[0];
  assign fwd_b_o  = sel[1];
  assign stall_o  = stall;
  assign bubble_o = stall;
endmodule

// File: rtl/hazard_fwd_chk.sv
module hazard_fwd_chk #(
  parameter int REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] id_rs_i,
  input logic [REG_W-1:0] id_rt_i,
  input logic             id_store_i,
  input logic [REG_W-1:0] ex_rd_i,
  input logic             ex_we_i,
  input logic             ex_load_i,
  input logic             mem_we_i,
  input logic             wb_we_i,
  input logic [1:0]       fwd_a_o,
  input logic [1:0]       fwd_b_o,
  input logic             stall_o,
  input logic             bubble_o,
  input logic             st_fwd_mem_o
);
  assert_zero_src_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rs_i == '0) |-> (fwd_a_o == 2'b00));

  assert_no_writer_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ex_we_i && !mem_we_i && !wb_we_i) |-> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00 && !stall_o));

  assert_ex_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_we_i && id_rs_i != '0 && ex_rd_i == id_rs_i) |-> (fwd_a_o == 2'b01));

  assert_stall_bubble_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o == bubble_o) && (!stall_o || (ex_load_i && ex_we_i)));

  assert_store_no_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_store_i && ex_load_i && ex_we_i && ex_rd_i != '0 &&
     id_rt_i == ex_rd_i && id_rs_i != ex_rd_i) |-> !stall_o);

  assert_st_fwd_origin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_fwd_mem_o |-> $past(id_store_i && ex_load_i && ex_we_i, 2));
endmodule

bind hazard_fwd_unit hazard_fwd_chk #(.REG_W(REG_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .id_rs_i      (id_rs_i),
  .id_rt_i      (id_rt_i),
  .id_store_i   (id_store_i),
  .ex_rd_i      (ex_rd_i),
  .ex_we_i      (ex_we_i),
  .ex_load_i    (ex_load_i),
  .mem_we_i     (mem_we_i),
  .wb_we_i      (wb_we_i),
  .fwd_a_o      (fwd_a_o),
  .fwd_b_o      (fwd_b_o),
  .stall_o      (stall_o),
  .bubble_o     (bubble_o),
  .st_fwd_mem_o (st_fwd_mem_o)
);

// File: tb/test_hazard_fwd_unit.sv
module test_hazard_fwd_unit;
  localparam int REG_W = 5;

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       stall;
    logic       st;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [REG_W-1:0] id_rs, id_rt, ex_rd, mem_rd, wb_rd;
  logic id_store, ex_we, ex_load, mem_we, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic stall, bubble, st_fwd;

  int checks = 0, failures = 0;
  bit done = 0;
  bit h1 = 0, h2 = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  hazard_fwd_unit #(.REG_W(REG_W)) i_hazard_fwd_unit (
    .clk_i(clk), .rst_ni(rst_ni),
    .id_rs_i(id_rs), .id_rt_i(id_rt), .id_store_i(id_store),
    .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_load),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
    .stall_o(stall), .bubble_o(bubble), .st_fwd_mem_o(st_fwd)
  );

  function automatic logic [1:0] pick(input logic [REG_W-1:0] s, input bit no_ex);
    if (s == 0) return 2'b00;
    if (!no_ex && ex_we && ex_rd == s) return 2'b01;
    if (mem_we && mem_rd == s) return 2'b10;
    if (wb_we && wb_rd == s) return 2'b11;
    return 2'b00;
  endfunction

  task automatic apply(input logic [REG_W-1:0] rs, rt, input logic st,
                       input logic [REG_W-1:0] exr, input logic exw, exl,
                       input logic [REG_W-1:0] mr, input logic mw,
                       input logic [REG_W-1:0] wr, input logic ww, input string tag);
    exp_t e;
    bit ld, scase;
    @(negedge clk);
    id_rs = rs; id_rt = rt; id_store = st;
    ex_rd = exr; ex_we = exw; ex_load = exl;
    mem_rd = mr; mem_we = mw; wb_rd = wr; wb_we = ww;
    ld    = exl && exw && exr != 0;
    scase = ld && st && rt == exr && rs != exr;
    e.a     = pick(rs, 1'b0);
    e.b     = pick(rt, scase);
    e.stall = ld && (rs == exr || (rt == exr && !st));
    e.st    = h2;
    e.tag   = tag;
    h2 = h1;
    h1 = scase;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #4;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (fwd_a !== e.a || fwd_b !== e.b || stall !== e.stall ||
            bubble !== e.stall || st_fwd !== e.st) begin
          failures++;
          $display("FAIL %s: got a=%b b=%b stall=%b bubble=%b st=%b exp a=%b b=%b stall=%b bubble=%b st=%b",
                   e.tag, fwd_a, fwd_b, stall, bubble, st_fwd,
                   e.a, e.b, e.stall, e.stall, e.st);
        end
      end
    end
  end

  initial begin : watchdog
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    id_rs = 0; id_rt = 0; id_store = 0; ex_rd = 0; ex_we = 0; ex_load = 0;
    mem_rd = 0; mem_we = 0; wb_rd = 0; wb_we = 0;
    // reset: pending flag held clear (R7)
    id_store = 1; id_rt = 7; ex_rd = 7; ex_we = 1; ex_load = 1;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (st_fwd !== 1'b0) begin
      failures++;
      $display("FAIL R7: got st=%b exp st=0", st_fwd);
    end
    @(negedge clk);
    id_store = 0; ex_we = 0; ex_load = 0;
    rst_ni = 1'b1;
    apply(3, 4, 0, 3, 0, 0, 3, 0, 4, 0, "R2 no writers");
    apply(3, 4, 0, 3, 1, 0, 0, 0, 0, 0, "R3 rs from EX");
    apply(3, 4, 0, 0, 0, 0, 4, 1, 4, 1, "R3 rt MEM over WB");
    apply(3, 4, 0, 0, 0, 0, 0, 0, 4, 1, "R3 rt from WB");
    apply(3, 3, 0, 3, 1, 0, 3, 1, 3, 1, "R3 EX over MEM and WB");
    apply(0, 0, 0, 0, 1, 1, 0, 1, 0, 1, "R1 register zero");
    apply(3, 9, 0, 3, 0, 1, 3, 1, 9, 0, "R2 EX disabled falls to MEM");
    apply(5, 1, 0, 5, 1, 1, 0, 0, 0, 0, "R4 load-use on rs");
    apply(2, 6, 0, 6, 1, 1, 0, 0, 0, 0, "R4 load-use on rt");
    apply(5, 5, 0, 5, 0, 1, 0, 0, 0, 0, "R2 load without write enable");
    apply(2, 7, 1, 7, 1, 1, 7, 1, 0, 0, "R5 store data after load");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 flag not yet");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 flag two cycles later");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 flag single cycle");
    apply(7, 7, 1, 7, 1, 1, 0, 0, 0, 0, "R4 store address after load");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 no flag after stall");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 no flag after stall");
    apply(1, 7, 1, 7, 1, 0, 0, 0, 0, 0, "R5 store after non-load uses EX");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 no flag after non-load");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 no flag after non-load");
    apply(4, 8, 1, 8, 1, 1, 0, 0, 8, 1, "R5 store data, rt from WB");
    apply(0, 0, 1, 0, 1, 1, 0, 0, 0, 0, "R1 store with zero regs");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 flag after second store");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 flag cleared");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule